// File: doc/BRIEF.md
# Embedded-Sync Video Stream Decoder

This block sits directly behind an 8-bit 4:2:2 component video input. Luma and chroma bytes share that input and arrive at twice the sample rate. The block needs no separate sync pins. It recovers all line and field timing from the timing reference codes inside the byte stream. A reference code is three fixed bytes `FF 00 00` followed by a status byte. The status byte carries the field, vertical-blanking and end/start flags, together with four protection bits that guard those flags.

Every status byte that passes the protection check updates the field and blanking outputs. A start code on an active line opens a window of exactly one line's worth of active bytes. The bytes in that window are presented with a data-valid strobe and a colour-component tag. A status byte that fails its check is dropped and reported with a single-cycle error pulse. The block also produces start-of-line and start-of-field pulses and a count of lines within the current field. All outputs are registered and appear two clock edges after the corresponding input byte.

Top module: `vid_sync_decoder`

## Requirements
- R1: A byte is taken as a status byte only when it follows the bytes FF, 00, 00 in that order and its bit 7 is 1. In a status byte, bit 6 is the field flag F, bit 5 the vertical flag V and bit 4 the position flag H. H=1 marks an end-of-active code and H=0 marks a start-of-active code.
- R2: Status bits 3..0 must equal V^H, F^H, F^V and F^V^H. If they do not, `prot_err` pulses high for one cycle, two edges after the status byte. The byte then changes no field, blanking, line-count or window state.
- R3: After reset, `field`=0, `vblank`=1, `hblank`=1, `line_num`=0 and every strobe and pulse is 0.
- R4: On each accepted code, `field` takes F and `vblank` takes V. An end code sets `hblank` and a start code clears it.
- R5: After an accepted start code with V=0, exactly ACTIVE_BYTES (default 1440) following bytes are driven on `dout` with `dv`=1, each two edges after it entered. A start code with V=1 marks no byte valid.
- R6: `comp` tags valid bytes as 0=Cb, 1=Y, 2=Cr, cycling Cb, Y, Cr, Y from the first byte after every start code.
- R7: An accepted end code inside an open window closes it at once. Its status byte and all later bytes are not valid, while the three preamble bytes before it stay valid.
- R8: `sol` pulses for one cycle on each accepted start code. `line_num` counts accepted start codes since the last accepted code whose F differed from `field`, and is cleared by that code.
- R9: `sof` pulses on the first accepted start code with V=0 after a change of F. It never pulses before the first change of F after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Multiplexed video byte stream |
| dv | output | 1 | Active video byte present on `dout` |
| dout | output | 8 | Byte stream delayed by two edges |
| comp | output | 2 | Component of the valid byte: 0 Cb, 1 Y, 2 Cr |
| field | output | 1 | Current field flag |
| vblank | output | 1 | Vertical blanking indicator |
| hblank | output | 1 | Horizontal blanking indicator |
| sol | output | 1 | Start-of-line pulse |
| sof | output | 1 | Start-of-field pulse |
| prot_err | output | 1 | Protection-bit mismatch pulse |
| line_num | output | LINE_W | Start codes seen in the current field |

## Verification
A stuck or stale remaining-byte counter shows up at once as a wrong number of valid bytes per line. The scoreboard then either runs dry or keeps items left over when the line's end code arrives. A wrong phase counter mislabels `comp` on the second valid byte of a line. A wrong field or pending-start state shows up as a missing or extra `sof`, or as a `line_num` that was not cleared, no later than the first active line of the next field. A status byte wrongly accepted after a protection error moves `hblank` or `line_num` within two cycles.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    typedef enum logic [1:0] {
        COMP_CB = 2'd0,
        COMP_Y  = 2'd1,
        COMP_CR = 2'd2
    } comp_e;

    // Decoded reference code, one cycle after its status byte
    typedef struct packed {
        logic vld;   // status byte passed protection check
        logic err;   // status byte failed protection check
        logic f;
        logic v;
        logic h;
    } ref_code_t;

    function automatic logic [3:0] prot_bits(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic comp_e phase_to_comp(input logic [1:0] ph);
        case (ph)
            2'd0:    return COMP_CB;
            2'd2:    return COMP_CR;
            default: return COMP_Y;
        endcase
    endfunction

endpackage

// File: rtl/vsd_code_finder.sv
module vsd_code_finder
    import vsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output ref_code_t     code,
    output logic [DW-1:0] byte_o
);
    localparam logic [DW-1:0] ALL_ONES  = {DW{1'b1}};
    localparam logic [DW-1:0] ALL_ZEROS = {DW{1'b0}};

    typedef struct packed {
        logic [1:0]    pre;   // preamble bytes matched so far
        ref_code_t     code;
        logic [DW-1:0] byt;
    } fstate_t;

    fstate_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.byt      = din;
        s_d.code     = '0;
        s_d.code.f   = din[DW-2];
        s_d.code.v   = din[DW-3];
        s_d.code.h   = din[DW-4];
        case (s_q.pre)
            2'd0: s_d.pre = (din == ALL_ONES) ? 2'd1 : 2'd0;
            2'd1: s_d.pre = (din == ALL_ZEROS) ? 2'd2 : ((din == ALL_ONES) ? 2'd1 : 2'd0);
            2'd2: s_d.pre = (din == ALL_ZEROS) ? 2'd3 : ((din == ALL_ONES) ? 2'd1 : 2'd0);
            default: begin
                s_d.pre = (din == ALL_ONES) ? 2'd1 : 2'd0;
                if (din[DW-1]) begin
                    if (din[3:0] == prot_bits(din[DW-2], din[DW-3], din[DW-4]))
                        s_d.code.vld = 1'b1;
                    else
                        s_d.code.err = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign code   = s_q.code;
    assign byte_o = s_q.byt;

    AST_ERR_EXCLUDES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.code.err |-> !s_q.code.vld);                                   // R2
    AST_CODE_NEEDS_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.code.vld || s_q.code.err) |-> $past(s_q.pre) == 2'd3);        // R1

endmodule

// File: rtl/vsd_timing.sv
module vsd_timing
    import vsd_pkg::*;
#(
    parameter int DW           = 8,
    parameter int ACTIVE_BYTES = 1440,
    parameter int LINE_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ref_code_t         code,
    input  logic [DW-1:0]     byte_i,
    output logic              dv,
    output logic [DW-1:0]     dout,
    output logic [1:0]        comp,
    output logic              field,
    output logic              vblank,
    output logic              hblank,
    output logic              sol,
    output logic              sof,
    output logic              prot_err,
    output logic [LINE_W-1:0] line_num
);
    localparam int AW = $clog2(ACTIVE_BYTES + 1);
    localparam logic [AW-1:0] WIN_LEN = AW'(ACTIVE_BYTES);

    typedef struct packed {
        logic [AW-1:0]     rem;
        logic [1:0]        phase;
        logic              pend;
        logic [LINE_W-1:0] line;
        logic              field;
        logic              vblank;
        logic              hblank;
        logic              dv;
        logic [DW-1:0]     dout;
        comp_e             comp;
        logic              sol;
        logic              sof;
        logic              perr;
    } tstate_t;

    tstate_t t_d, t_q;
    logic    fchg;

    always_comb begin
        t_d      = t_q;
        t_d.dv   = 1'b0;
        t_d.sol  = 1'b0;
        t_d.sof  = 1'b0;
        t_d.perr = code.err;
        t_d.dout = byte_i;
        fchg     = code.f != t_q.field;
        if (code.vld) begin
            t_d.field  = code.f;
            t_d.vblank = code.v;
            t_d.hblank = code.h;
            t_d.rem    = '0;
            if (fchg) begin
                t_d.line = '0;
                t_d.pend = 1'b1;
            end
            if (!code.h) begin
                t_d.line  = (fchg ? '0 : t_q.line) + LINE_W'(1);
                t_d.sol   = 1'b1;
                t_d.phase = 2'd0;
                if (!code.v) begin
                    t_d.rem = WIN_LEN;
                    if (t_q.pend || fchg) begin
                        t_d.sof  = 1'b1;
                        t_d.pend = 1'b0;
                    end
                end
            end
        end else if (t_q.rem != '0) begin
            t_d.dv    = 1'b1;
            t_d.rem   = t_q.rem - AW'(1);
            t_d.phase = t_q.phase + 2'd1;
            t_d.comp  = phase_to_comp(t_q.phase);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q        <= '0;
            t_q.vblank <= 1'b1;
            t_q.hblank <= 1'b1;
            t_q.comp   <= COMP_CB;
        end else begin
            t_q <= t_d;
        end
    end

    assign dv       = t_q.dv;
    assign dout     = t_q.dout;
    assign comp     = t_q.comp;
    assign field    = t_q.field;
    assign vblank   = t_q.vblank;
    assign hblank   = t_q.hblank;
    assign sol      = t_q.sol;
    assign sof      = t_q.sof;
    assign prot_err = t_q.perr;
    assign line_num = t_q.line;

    // run length of consecutive valid bytes, kept apart from the window counter
    logic [AW:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (t_q.dv) run_q <= run_q + (AW+1)'(1);
        else             run_q <= '0;
    end

    AST_RUN_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (AW+1)'(ACTIVE_BYTES));                                    // R5
    AST_VALID_NOT_IN_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.dv |-> !t_q.hblank);                                            // R7
    AST_ERR_FREEZES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.perr |-> $stable(t_q.field) && $stable(t_q.vblank) && $stable(t_q.hblank)
                     && $stable(t_q.line));                                 // R2
    AST_FIRST_BYTE_IS_CB: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.sol && !t_q.vblank) |=> t_q.dv && t_q.comp == COMP_CB);        // R6
    AST_SOF_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.sof |-> t_q.sol && !t_q.vblank && !t_q.hblank);                 // R9
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.sol |-> (t_q.line == $past(t_q.line) + LINE_W'(1)) || (t_q.line == LINE_W'(1))); // R8

endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder
    import vsd_pkg::*;
#(
    parameter int DW           = 8,
    parameter int ACTIVE_BYTES = 1440,
    parameter int LINE_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     din,
    output logic              dv,
    output logic [DW-1:0]     dout,
    output logic [1:0]        comp,
    output logic              field,
    output logic              vblank,
    output logic              hblank,
    output logic              sol,
    output logic              sof,
    output logic              prot_err,
    output logic [LINE_W-1:0] line_num
);
    ref_code_t     code_w;
    logic [DW-1:0] byte_w;

    vsd_code_finder #(.DW(DW)) u_find (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .code   (code_w),
        .byte_o (byte_w)
    );

    vsd_timing #(.DW(DW), .ACTIVE_BYTES(ACTIVE_BYTES), .LINE_W(LINE_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (code_w),
        .byte_i   (byte_w),
        .dv       (dv),
        .dout     (dout),
        .comp     (comp),
        .field    (field),
        .vblank   (vblank),
        .hblank   (hblank),
        .sol      (sol),
        .sof      (sof),
        .prot_err (prot_err),
        .line_num (line_num)
    );

endmodule

// File: tb/sim_vid_sync_decoder.sv
module sim_vid_sync_decoder;
    localparam int ACT = 1440;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h10;
    logic       dv, field, vblank, hblank, sol, sof, prot_err;
    logic [7:0] dout;
    logic [1:0] comp;
    logic [9:0] line_num;

    always #4 clk = ~clk;

    vid_sync_decoder u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .dv(dv), .dout(dout), .comp(comp),
        .field(field), .vblank(vblank), .hblank(hblank), .sol(sol), .sof(sof),
        .prot_err(prot_err), .line_num(line_num)
    );

    typedef struct { logic [7:0] d; logic [1:0] c; } exp_t;
    exp_t exp_q[$];

    int total = 0, bad = 0;
    int sol_cnt = 0, sof_cnt = 0, err_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [1:0] tag_of(input int i);
        case (i % 4)
            0: return 2'd0;
            2: return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        din = b;
    endtask

    task automatic push(input logic [7:0] b, input int i);
        exp_t e;
        e.d = b;
        e.c = tag_of(i);
        exp_q.push_back(e);
    endtask

    task automatic code(input logic f, input logic v, input logic h, input logic [3:0] flip);
        put(8'hFF); put(8'h00); put(8'h00);
        put(xy(f, v, h) ^ {4'h0, flip});
    endtask

    task automatic blank(input int n);
        for (int i = 0; i < n; i++) put((i % 2) ? 8'h10 : 8'h80);
    endtask

    // nact: number of bytes after the start code; early: end code after them
    task automatic line(input logic f, input logic v, input int nact, input bit early);
        code(f, v, 1'b1, 4'h0);
        blank(8);
        chk(hblank == 1'b1, "R4 hblank after end code", hblank, 1);
        chk(field == f, "R4 field follows F", field, f);
        code(f, v, 1'b0, 4'h0);
        for (int i = 0; i < nact; i++) begin
            logic [7:0] b;
            b = v ? 8'h10 : 8'(16 + (i * 7) % 200);
            put(b);
            if (!v) push(b, i);
            if (i == 3) begin
                chk(hblank == 1'b0, "R4 hblank cleared by start code", hblank, 0);
                chk(vblank == v, "R4 vblank follows V", vblank, v);
            end
        end
        if (early) begin
            put(8'hFF); push(8'hFF, nact);
            put(8'h00); push(8'h00, nact + 1);
            put(8'h00); push(8'h00, nact + 2);
            put(xy(f, v, 1'b1));
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (dv) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected valid byte", dout, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(dout == e.d, "R5 valid byte value", dout, e.d);
                    chk(comp == e.c, "R6 component tag", comp, e.c);
                end
            end
            if (sol) sol_cnt++;
            if (sof) sof_cnt++;
            if (prot_err) err_cnt++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(dv == 0 && sol == 0 && sof == 0 && prot_err == 0, "R3 strobes after reset",
            {dv, sol, sof, prot_err}, 0);
        chk(field == 0, "R3 field after reset", field, 0);
        chk(vblank == 1 && hblank == 1, "R3 blanking after reset", {vblank, hblank}, 3);
        chk(line_num == 0, "R3 line count after reset", line_num, 0);

        // top field: two blanking lines, two active lines
        line(1'b0, 1'b1, 16, 0);
        line(1'b0, 1'b1, 16, 0);
        chk(line_num == 2, "R8 line count in blanking", line_num, 2);
        line(1'b0, 1'b0, ACT, 0);
        line(1'b0, 1'b0, ACT, 0);
        blank(4);
        chk(exp_q.size() == 0, "R5 exact window length", exp_q.size(), 0);
        chk(sof_cnt == 0, "R9 no field start before F changes", sof_cnt, 0);
        chk(line_num == 4, "R8 line count after four lines", line_num, 4);

        // bottom field
        line(1'b1, 1'b1, 16, 0);
        chk(line_num == 1, "R8 line count cleared on F change", line_num, 1);
        chk(sof_cnt == 0, "R9 no field start on blanking line", sof_cnt, 0);
        line(1'b1, 1'b0, ACT, 0);
        blank(4);
        chk(sof_cnt == 1, "R9 field start on first active line", sof_cnt, 1);
        chk(sol_cnt == 6, "R8 one start pulse per start code", sol_cnt, 6);

        // corrupted start code
        code(1'b1, 1'b0, 1'b1, 4'h0);
        blank(8);
        code(1'b1, 1'b0, 1'b0, 4'h4);
        blank(20);
        chk(err_cnt == 1, "R2 protection error pulse", err_cnt, 1);
        chk(hblank == 1, "R2 bad code leaves hblank", hblank, 1);
        chk(line_num == 2, "R2 bad code leaves line count", line_num, 2);
        chk(sol_cnt == 6, "R2 bad code gives no line start", sol_cnt, 6);
        chk(exp_q.size() == 0, "R2 bad code opens no window", exp_q.size(), 0);

        // early end code
        line(1'b1, 1'b0, 20, 1);
        blank(8);
        chk(exp_q.size() == 0, "R7 preamble bytes valid in window", exp_q.size(), 0);
        chk(hblank == 1, "R7 early end sets hblank", hblank, 1);
        chk(err_cnt == 1, "R1 early end code accepted", err_cnt, 1);

        // back to top field
        line(1'b0, 1'b0, ACT, 0);
        blank(8);
        chk(sof_cnt == 2, "R9 field start after second F change", sof_cnt, 2);
        chk(line_num == 1, "R8 line count in new field", line_num, 1);
        chk(field == 0, "R4 field returns to 0", field, 0);
        chk(sol_cnt == 8, "R8 total start pulses", sol_cnt, 8);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule